// File: doc/BRIEF.md
# Vertical register sweep pulse generator

This block produces the fast burst of vertical transfer pulses that empties the vertical shift registers of an interline image sensor before a frame-mode readout. A frame sequencer raises an enable; the block waits for the first clock of line 510. From then on it drives two phase groups inside every line. The first group (V1/V3 phases) fires every 24 clocks, starting at horizontal position 2. The second group (V2/V4 phases) fires on the same 24-clock spacing, 12 clocks later, starting at position 14.

A transfer stage is one second-group pulse that follows a first-group pulse. The block counts stages. After exactly 780 stages it suppresses all further pulses and raises a done flag. At the default spacing that takes twelve lines. If the sequencer drops the enable before then, no new pulse starts. A pulse already in flight still completes, and an incomplete flag is raised.

The block does not count horizontal position or lines itself. It takes both from the sensor timing generator, which runs at the pixel clock.

Top module: `csweep_gen`

## Requirements
- R1: While reset is asserted, and in the cycles after its release until a sweep starts, both pulse outputs and both flags are low.
- R2: A sweep starts only when `sweep_en` is high while `line_num` is 510 and `h_pos` is 1. With `sweep_en` high on earlier lines, no pulse appears.
- R3: During a sweep, `vs_grp13` rises in the cycle after `h_pos` was sampled at 2+24k, for k = 0 to 64. The last such position in a line is 1538.
- R4: During a sweep, `vs_grp24` rises in the cycle after `h_pos` was sampled at 14+24k, for k = 0 to 64. The last such position in a line is 1550.
- R5: Every pulse stays high for exactly 6 cycles, and the two outputs are never high together.
- R6: A stage is a `vs_grp24` pulse that follows a `vs_grp13` pulse. `sweep_done` rises in the same cycle as the rise of the 780th stage pulse, and no pulse rises on either output after that.
- R7: `sweep_done` holds while `sweep_en` stays high. It clears in the cycle after `sweep_en` is sampled low.
- R8: If `sweep_en` is sampled low during a sweep, no new pulse starts and a pulse already running completes its full width. `sweep_incomplete` rises in the cycle after that sample, and `sweep_done` stays low.
- R9: If `sweep_en` is sampled low exactly at `h_pos` 1550 of the twelfth swept line, the 780th stage pulse is suppressed. The sweep ends with 779 stages, `sweep_incomplete` high and `sweep_done` low.
- R10: `sweep_incomplete` clears in the cycle after `sweep_en` is sampled high again. No pulses follow until the start condition of R2 is met once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_num | input | 10 | Current line number from the timing generator (1 to 525) |
| h_pos | input | 11 | Horizontal clock position within the line (1 to 1560) |
| sweep_en | input | 1 | Sweep request from the frame sequencer |
| vs_grp13 | output | 1 | Sweep pulse for the V1A/V1B/V3A/V3B phase group |
| vs_grp24 | output | 1 | Sweep pulse for the V2/V4 phase group |
| sweep_done | output | 1 | All 780 stages delivered |
| sweep_incomplete | output | 1 | Sweep stopped early because the enable was withdrawn |

## Verification
Two functions meet in one cycle: completion and withdrawal of the enable.

- **Completion.** The rise of the final stage pulse and the rise of `sweep_done` fall in the same cycle. The bench checks that the flag appears exactly with the 780th stage and that nothing rises afterwards.
- **Withdrawal at the last slot.** The bench also drops `sweep_en` exactly at the sampled slot of that final stage. It then expects the withdrawal to win: 779 stages, the incomplete flag, and no done flag.
- **Reference model.** A per-cycle model computes the expected values with modulo arithmetic on the driven position. It judges every cycle of each scenario, and pulse counts and flags are checked at the end.

// File: rtl/csweep_pkg.sv
package csweep_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_DONE = 2'd2,
    SW_HALT = 2'd3
  } sweep_st_e;
endpackage

// File: rtl/csweep_rst_sync.sv
module csweep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/csweep_phase.sv
// One phase group: finds its slots in the line and stretches each started
// slot to a fixed pulse width. Slots advance even when starts are blocked,
// so the grid stays aligned to the line on every line.
module csweep_phase #(
  parameter int H_W     = 11,
  parameter int FIRST   = 2,
  parameter int PERIOD  = 24,
  parameter int LAST    = 1538,
  parameter int PULSE_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] h_pos,
  input  logic           allow,
  output logic           slot_go,
  output logic           pulse
);
  localparam int PW_W = $clog2(PULSE_W + 1);

  logic [H_W-1:0]  slot_q, slot_d;
  logic            slot_ce;
  logic [PW_W-1:0] wid_q, wid_d;
  logic            wid_ce;
  logic            line_head, slot_hit;

  always_comb begin
    line_head = (h_pos == H_W'(1));
    slot_hit  = (h_pos == slot_q) && (h_pos <= H_W'(LAST));
    slot_go   = slot_hit && allow;
    slot_ce   = line_head || slot_hit;
    slot_d    = line_head ? H_W'(FIRST) : (slot_q + H_W'(PERIOD));
    wid_ce    = slot_go || (wid_q != '0);
    wid_d     = slot_go ? PW_W'(PULSE_W) : (wid_q - PW_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= H_W'(FIRST);
      wid_q  <= '0;
    end else begin
      if (slot_ce) slot_q <= slot_d;
      if (wid_ce)  wid_q  <= wid_d;
    end
  end

  assign pulse = (wid_q != '0);
endmodule

// File: rtl/csweep_seq.sv
// Sweep sequencer: start detection, stage counting, completion and abort.
module csweep_seq
  import csweep_pkg::*;
#(
  parameter int H_W        = 11,
  parameter int L_W        = 10,
  parameter int START_LINE = 510,
  parameter int STAGES     = 780
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sweep_en,
  input  logic [L_W-1:0] line_num,
  input  logic [H_W-1:0] h_pos,
  input  logic           first_go,
  input  logic           second_go,
  output logic           allow,
  output logic           done,
  output logic           incomplete
);
  localparam int CNT_W = $clog2(STAGES + 1);

  sweep_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             pair_q, pair_d, pair_ce;
  logic             stage_go, start_ok;

  always_comb begin
    allow    = (st_q == SW_RUN) && sweep_en;
    start_ok = sweep_en && (line_num == L_W'(START_LINE)) && (h_pos == H_W'(1));
    stage_go = second_go && pair_q;
    st_d     = st_q;
    cnt_ce   = 1'b0;
    cnt_d    = cnt_q + CNT_W'(1);
    pair_ce  = 1'b0;
    pair_d   = pair_q;
    unique case (st_q)
      SW_IDLE: begin
        if (start_ok) begin
          st_d    = SW_RUN;
          cnt_ce  = 1'b1;
          cnt_d   = '0;
          pair_ce = 1'b1;
          pair_d  = 1'b0;
        end
      end
      SW_RUN: begin
        if (!sweep_en) begin
          st_d = SW_HALT;
        end else begin
          if (first_go) begin
            pair_ce = 1'b1;
            pair_d  = 1'b1;
          end
          if (stage_go) begin
            cnt_ce  = 1'b1;
            pair_ce = 1'b1;
            pair_d  = 1'b0;
            if (cnt_q == CNT_W'(STAGES - 1)) st_d = SW_DONE;
          end
        end
      end
      SW_DONE: if (!sweep_en) st_d = SW_IDLE;
      SW_HALT: if (sweep_en)  st_d = SW_IDLE;
      default: st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      cnt_q  <= '0;
      pair_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (pair_ce) pair_q <= pair_d;
    end
  end

  assign done       = (st_q == SW_DONE);
  assign incomplete = (st_q == SW_HALT);
endmodule

// File: rtl/csweep_gen.sv
module csweep_gen #(
  parameter int H_W        = 11,
  parameter int L_W        = 10,
  parameter int START_LINE = 510,
  parameter int PERIOD     = 24,
  parameter int FIRST_A    = 2,
  parameter int LAST_A     = 1538,
  parameter int FIRST_B    = 14,
  parameter int LAST_B     = 1550,
  parameter int PULSE_W    = 6,
  parameter int STAGES     = 780
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [L_W-1:0] line_num,
  input  logic [H_W-1:0] h_pos,
  input  logic           sweep_en,
  output logic           vs_grp13,
  output logic           vs_grp24,
  output logic           sweep_done,
  output logic           sweep_incomplete
);
  localparam int N_GRP = 2;

  logic             rst_int_n;
  logic             allow;
  logic [N_GRP-1:0] grp_go, grp_pulse;

  csweep_rst_sync u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_int_n(rst_int_n)
  );

  csweep_seq #(
    .H_W       (H_W),
    .L_W       (L_W),
    .START_LINE(START_LINE),
    .STAGES    (STAGES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sweep_en  (sweep_en),
    .line_num  (line_num),
    .h_pos     (h_pos),
    .first_go  (grp_go[0]),
    .second_go (grp_go[1]),
    .allow     (allow),
    .done      (sweep_done),
    .incomplete(sweep_incomplete)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int G_FIRST = (g == 0) ? FIRST_A : FIRST_B;
    localparam int G_LAST  = (g == 0) ? LAST_A  : LAST_B;
    csweep_phase #(
      .H_W    (H_W),
      .FIRST  (G_FIRST),
      .PERIOD (PERIOD),
      .LAST   (G_LAST),
      .PULSE_W(PULSE_W)
    ) u_phase (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .h_pos  (h_pos),
      .allow  (allow),
      .slot_go(grp_go[g]),
      .pulse  (grp_pulse[g])
    );
  end

  assign vs_grp13 = grp_pulse[0];
  assign vs_grp24 = grp_pulse[1];
endmodule

// File: rtl/csweep_gen_chk.sv
module csweep_gen_chk #(
  parameter int H_W     = 11,
  parameter int PERIOD  = 24,
  parameter int FIRST_A = 2,
  parameter int LAST_A  = 1538,
  parameter int FIRST_B = 14,
  parameter int LAST_B  = 1550,
  parameter int PULSE_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [H_W-1:0] h_pos,
  input logic           sweep_en,
  input logic           vs_grp13,
  input logic           vs_grp24,
  input logic           sweep_done,
  input logic           sweep_incomplete
);
  logic [15:0] run_a, run_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a <= '0;
      run_b <= '0;
    end else begin
      run_a <= vs_grp13 ? run_a + 16'd1 : 16'd0;
      run_b <= vs_grp24 ? run_b + 16'd1 : 16'd0;
    end
  end

  AST_A_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_grp13) |-> ((int'($past(h_pos)) >= FIRST_A) && (int'($past(h_pos)) <= LAST_A) &&
                         ((int'($past(h_pos)) - FIRST_A) % PERIOD == 0)));               // R3
  AST_B_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_grp24) |-> ((int'($past(h_pos)) >= FIRST_B) && (int'($past(h_pos)) <= LAST_B) &&
                         ((int'($past(h_pos)) - FIRST_B) % PERIOD == 0)));               // R4
  AST_A_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_grp13) |-> (run_a == 16'(PULSE_W)));                                        // R5
  AST_B_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_grp24) |-> (run_b == 16'(PULSE_W)));                                        // R5
  AST_GROUPS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(vs_grp13 && vs_grp24));                                                            // R5
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_done) |-> $rose(vs_grp24));                                              // R6
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && $past(sweep_done)) |-> (!$rose(vs_grp13) && !$rose(vs_grp24)));       // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && sweep_en) |=> sweep_done);                                            // R7
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_incomplete) |-> !$past(sweep_en));                                       // R8
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_done && sweep_incomplete));                                                  // R8
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vs_grp13) || $rose(vs_grp24)) |-> $past(sweep_en));                           // R9
endmodule

bind csweep_gen csweep_gen_chk #(
  .H_W    (H_W),
  .PERIOD (PERIOD),
  .FIRST_A(FIRST_A),
  .LAST_A (LAST_A),
  .FIRST_B(FIRST_B),
  .LAST_B (LAST_B),
  .PULSE_W(PULSE_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .h_pos           (h_pos),
  .sweep_en        (sweep_en),
  .vs_grp13        (vs_grp13),
  .vs_grp24        (vs_grp24),
  .sweep_done      (sweep_done),
  .sweep_incomplete(sweep_incomplete)
);

// File: tb/csweep_gen_tb.sv
`timescale 1ns/100ps
module csweep_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] line_num;
  logic [10:0] h_pos;
  logic       sweep_en;
  logic       vs_grp13, vs_grp24, sweep_done, sweep_incomplete;

  always #2.5 clk = ~clk;

  csweep_gen u_dut (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .h_pos(h_pos), .sweep_en(sweep_en),
    .vs_grp13(vs_grp13), .vs_grp24(vs_grp24), .sweep_done(sweep_done),
    .sweep_incomplete(sweep_incomplete)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Scenario table: drop line, drop position (0 = never), expected first-group
  // pulses, expected second-group pulses, expected done, expected incomplete.
  localparam int NROW = 4;
  localparam int TBL [NROW][6] = '{
    '{0,   0,    780, 780, 1, 0},   // full sweep                 R6
    '{515, 700,  355, 354, 0, 1},   // mid-sweep withdrawal       R8
    '{521, 1550, 780, 779, 0, 1},   // withdrawal at final slot   R9
    '{510, 2,    0,   0,   0, 1}    // withdrawal right at start  R8
  };

  // Reference model state
  int m_st, m_cnt, m_wa, m_wb;
  bit m_pair;
  int mism, rise_a, rise_b, idle_rise, first_line;
  bit prev_a, prev_b;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_st = 0; m_cnt = 0; m_wa = 0; m_wb = 0; m_pair = 1'b0;
    mism = 0; rise_a = 0; rise_b = 0; idle_rise = 0; first_line = -1;
    prev_a = 1'b0; prev_b = 1'b0;
  endtask

  task automatic step(input int ln, input int hp, input bit en);
    bit allow, a_go, b_go, staged;
    int nst;
    line_num = 10'(ln);
    h_pos    = 11'(hp);
    sweep_en = en;
    allow  = (m_st == 1) && en;
    a_go   = allow && hp >= 2  && hp <= 1538 && ((hp - 2)  % 24 == 0);
    b_go   = allow && hp >= 14 && hp <= 1550 && ((hp - 14) % 24 == 0);
    staged = b_go && m_pair;
    if (a_go) m_wa = 6; else if (m_wa > 0) m_wa--;
    if (b_go) m_wb = 6; else if (m_wb > 0) m_wb--;
    nst = m_st;
    case (m_st)
      0: if (en && ln == 510 && hp == 1) begin nst = 1; m_cnt = 0; m_pair = 1'b0; end
      1: if (!en) nst = 3;
         else begin
           if (a_go) m_pair = 1'b1;
           if (staged) begin
             m_pair = 1'b0;
             if (m_cnt == 779) nst = 2;
             m_cnt++;
           end
         end
      2: if (!en) nst = 0;
      default: if (en) nst = 0;
    endcase
    m_st = nst;
    @(posedge clk);
    #1;
    if (vs_grp13 !== (m_wa != 0) || vs_grp24 !== (m_wb != 0) ||
        sweep_done !== (m_st == 2) || sweep_incomplete !== (m_st == 3)) mism++;
    if (vs_grp13 && !prev_a) begin
      rise_a++;
      if (first_line < 0) first_line = ln;
      if (ln < 510) idle_rise++;
    end
    if (vs_grp24 && !prev_b) begin
      rise_b++;
      if (ln < 510) idle_rise++;
    end
    prev_a = vs_grp13;
    prev_b = vs_grp24;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sweep_en = 1'b0; line_num = 10'd508; h_pos = 11'd1550;
    repeat (3) @(posedge clk);
    #1;
    chk(vs_grp13 == 0 && vs_grp24 == 0 && sweep_done == 0 && sweep_incomplete == 0,
        "R1 outputs in reset", {vs_grp13, vs_grp24, sweep_done, sweep_incomplete}, 0);
    rst_n = 1'b1;
    model_clear();
    for (int h = 1551; h <= 1560; h++) step(508, h, 1'b1);
    chk(vs_grp13 == 0 && vs_grp24 == 0 && sweep_done == 0 && sweep_incomplete == 0,
        "R1 outputs after release", {vs_grp13, vs_grp24, sweep_done, sweep_incomplete}, 0);
  endtask

  initial begin
    for (int r = 0; r < NROW; r++) begin
      int dl, dh;
      bit en;
      dl = TBL[r][0];
      dh = TBL[r][1];
      do_reset();
      for (int ln = 509; ln <= 522; ln++) begin
        for (int h = 1; h <= 1560; h++) begin
          en = (dl == 0) || (ln < dl) || (ln == dl && h < dh);
          step(ln, h, en);
        end
      end
      chk(mism == 0, $sformatf("R3 R4 R5 per-cycle model row %0d", r), mism, 0);
      chk(rise_a == TBL[r][2], $sformatf("R3 first-group pulses row %0d", r), rise_a, TBL[r][2]);
      chk(rise_b == TBL[r][3], $sformatf("R6 second-group pulses row %0d", r), rise_b, TBL[r][3]);
      chk(sweep_done == TBL[r][4], $sformatf("R6 done flag row %0d", r), sweep_done, TBL[r][4]);
      chk(sweep_incomplete == TBL[r][5], $sformatf("R8 incomplete flag row %0d", r),
          sweep_incomplete, TBL[r][5]);
      chk(idle_rise == 0, $sformatf("R2 pulses before line 510 row %0d", r), idle_rise, 0);
      if (TBL[r][2] > 0)
        chk(first_line == 510, $sformatf("R2 first pulse line row %0d", r), first_line, 510);
      if (TBL[r][4] == 1) begin
        chk(sweep_done == 1, "R7 done held with enable high", sweep_done, 1);
        step(523, 1, 1'b0);
        chk(sweep_done == 0, "R7 done cleared after enable low", sweep_done, 0);
      end
      if (TBL[r][5] == 1) begin
        if (r == 2) chk(sweep_done == 0, "R9 no done after final-slot withdrawal", sweep_done, 0);
        step(523, 1, 1'b1);
        chk(sweep_incomplete == 0, "R10 incomplete cleared on enable high",
            sweep_incomplete, 0);
        rise_a = 0; rise_b = 0;
        for (int h = 2; h <= 400; h++) step(523, h, 1'b1);
        chk(rise_a + rise_b == 0, "R10 no restart outside line 510", rise_a + rise_b, 0);
      end
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule